// File: doc/BRIEF.md
# Page Address and Status Controller

This block keeps the addressing and status state of a serial flash slave whose array is organised in erase blocks of pages. A command decoder in front of it presents one-cycle strobes: load address, page increment, read, write, erase, top-block read, top-block write, write enable and write disable. For every operation strobe the controller either starts an array operation, refuses it because writing is locked, or flags it because the address is not valid. When it starts an operation it registers the effective array address.

A cycle counter stands in for the array sequencer. It holds the block busy for a parameter-set number of cycles for each operation type. While chip select is low and no data is leaving the device, the controller drives the ready/busy level onto the serial output. It also assembles the status byte that a status-read command would shift out. Writes and erases land in a pass/fail flag taken from the array's fail input at completion. A completed erase leaves the address undefined until it is loaded again.

Top module: `pgstat_ctrl`

## Requirements
- R1: After reset the controller is ready, writing is locked, the pass flag is 1, and the address is not valid, so a read before any address load is flagged.
- R2: A load-address strobe stores the block and page arguments. A read or write then started reports that block and page on `eff_blk_o`/`eff_pg_o`. `eff_blk_o`/`eff_pg_o` change only when an operation starts. `op_kind_o` encodes 1 as read, 2 as write, 3 as erase, 4 as top-block read and 5 as top-block write.
- R3: The increment strobe advances the page. From page 127 it goes to page 0 of the next block. Stepping off page 127 of the last ordinary block (one below the top block) makes the address not valid.
- R4: Write, erase and top-block write are refused (`deny_o`) while writing is locked. Enable and disable are accepted while busy and affect only operations started afterwards.
- R5: A started operation holds `busy_o` for exactly T_READ, T_PROG or T_ERASE cycles, depending on its type. Read, write and erase strobes that arrive while busy are ignored, with no start, no refusal and no flag.
- R6: The status byte is defined as follows. Bit 7 is 1 when ready. Bit 6 is the pass flag. Bit 5 is the write-unlock state. Bit 0 is 1 for the large variant. Bits 4 to 1 are 0.
- R7: The top-block read and top-block write operations use the top block (127 small, 254 large) whatever block was loaded. They accept pages up to 127 on the small variant and up to 255 on the large variant.
- R8: An erase of the top block or beyond is refused. A completed erase makes the address not valid.
- R9: A read or write with an address that is not valid pulses `addr_err_o` and starts nothing. At most one of start, refusal and flag occurs per command.
- R10: With chip select low and no shift-out in progress, the serial output is 0 while busy and 1 when ready. During a shift-out it carries the shift bit. With chip select high the output enable is 0. The operation runs on regardless of chip select.
- R11: When a write, erase or top-block write completes, the pass flag takes the inverse of `arr_fail_i` sampled in its last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| cmd_set_addr_i | input | 1 | Load address strobe |
| arg_blk_i | input | BLK_W | Block argument (load address, erase) |
| arg_pg_i | input | PG_W | Page argument (load address) |
| cmd_incr_i | input | 1 | Page increment strobe |
| cmd_read_i | input | 1 | Read strobe |
| cmd_write_i | input | 1 | Write strobe |
| cmd_erase_i | input | 1 | Erase strobe, block from arg_blk_i |
| cmd_rd_last_i | input | 1 | Top-block read strobe |
| cmd_wr_last_i | input | 1 | Top-block write strobe |
| cmd_wen_i | input | 1 | Write unlock strobe |
| cmd_wdis_i | input | 1 | Write lock strobe |
| arr_fail_i | input | 1 | Array reports failure at completion |
| shift_out_i | input | 1 | Data shift-out in progress |
| shift_bit_i | input | 1 | Bit being shifted out |
| op_go_o | output | 1 | Operation started (one cycle) |
| op_kind_o | output | 3 | Kind of started operation |
| eff_blk_o | output | BLK_W | Effective array block |
| eff_pg_o | output | PG_W | Effective array page |
| deny_o | output | 1 | Operation refused (one cycle) |
| addr_err_o | output | 1 | Address not valid (one cycle) |
| busy_o | output | 1 | Array operation running |
| status_o | output | 8 | Status byte |
| so_o | output | 1 | Serial output level |
| so_oe_o | output | 1 | Serial output enable |

## Verification
The bound assertions check several rules on every cycle. A started operation is always busy. Start, refusal and flag never occur together. Any write or erase that starts saw writing unlocked in the cycle before. Top-block operations always use the top block, while an erase never does. The serial output is low whenever it shows busy, and the effective address moves only on a start. The exact busy length, the increment carry and overflow, and the address invalidation after an erase depend on histories of several commands. So do the enable/disable changes while busy and the pass/fail capture, and only the bench's reference model and directed scenarios can show them.

// File: rtl/pgstat_pkg.sv
// Shared types for the page address and status controller.
package pgstat_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_ERASE  = 3'd3,
        OP_RDLAST = 3'd4,
        OP_WRLAST = 3'd5
    } op_kind_t;
endpackage

// File: rtl/pgstat_timer.sv
// Operation timer: stands in for the array sequencer.
// Loads a per-kind cycle count on start and counts down; busy while non-zero.
// Assumes start_i only arrives while idle and every duration is at least 1.
module pgstat_timer
    import pgstat_pkg::*;
#(
    parameter int unsigned T_READ  = 9,
    parameter int unsigned T_PROG  = 40,
    parameter int unsigned T_ERASE = 60
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  op_kind_t kind_i,
    output logic     busy_o,
    output logic     done_o,
    output op_kind_t done_kind_o
);
    localparam int unsigned TMAX1 = (T_READ > T_PROG) ? T_READ : T_PROG;
    localparam int unsigned TMAX  = (TMAX1 > T_ERASE) ? TMAX1 : T_ERASE;
    localparam int unsigned CW    = $clog2(TMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load;
    op_kind_t      kind_q;

    // Pick the busy length for the kind being started.
    always_comb begin
        case (kind_i)
            OP_READ, OP_RDLAST:  load = CW'(T_READ);
            OP_WRITE, OP_WRLAST: load = CW'(T_PROG);
            OP_ERASE:            load = CW'(T_ERASE);
            default:             load = CW'(1);
        endcase
    end

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= OP_NONE;
        end else if (start_i) begin
            cnt_q  <= load;
            kind_q <= kind_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy_o      = (cnt_q != '0);
    assign done_o      = (cnt_q == CW'(1));
    assign done_kind_o = kind_q;
endmodule

// File: rtl/pgstat_addr.sv
// Address register: holds block, page and a valid flag.
// Increment carries page overflow into the block; stepping past the last
// ordinary block or finishing an erase clears the valid flag.
module pgstat_addr #(
    parameter int unsigned BLK_W   = 8,
    parameter int unsigned PG_W    = 8,
    parameter int unsigned PAGES   = 128,
    parameter int unsigned TOP_BLK = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PG_W-1:0]  pg_i,
    input  logic             incr_i,
    input  logic             inval_i,
    output logic [BLK_W-1:0] blk_o,
    output logic [PG_W-1:0]  pg_o,
    output logic             valid_o
);
    localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(PAGES - 1);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(TOP_BLK - 1);

    logic wrap;
    logic ovf;

    assign wrap = (pg_o >= LAST_PG);
    assign ovf  = wrap && (blk_o >= LAST_BLK);

    // Block and page: load wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_o <= '0;
            pg_o  <= '0;
        end else if (set_i) begin
            blk_o <= blk_i;
            pg_o  <= pg_i;
        end else if (incr_i) begin
            if (wrap) begin
                pg_o  <= '0;
                blk_o <= blk_o + BLK_W'(1);
            end else begin
                pg_o <= pg_o + PG_W'(1);
            end
        end
    end

    // Valid flag: set by a load, cleared by erase completion or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                    valid_o <= 1'b0;
        else if (set_i)                valid_o <= 1'b1;
        else if (inval_i)              valid_o <= 1'b0;
        else if (incr_i && ovf)        valid_o <= 1'b0;
    end
endmodule

// File: rtl/pgstat_status.sv
// Status state: write-unlock latch and pass/fail flag.
// Assumes done_i pulses for one cycle at the end of each operation.
module pgstat_status
    import pgstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wen_i,
    input  logic     wdis_i,
    input  logic     done_i,
    input  op_kind_t done_kind_i,
    input  logic     fail_i,
    output logic     wel_o,
    output logic     pass_o
);
    // Write-unlock latch, locked at reset, unlock wins if both arrive.
    always_ff @(posedge clk) begin
        if (!rst_n)      wel_o <= 1'b0;
        else if (wen_i)  wel_o <= 1'b1;
        else if (wdis_i) wel_o <= 1'b0;
    end

    // Pass flag updated only by completing program or erase operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pass_o <= 1'b1;
        else if (done_i && (done_kind_i == OP_WRITE || done_kind_i == OP_ERASE ||
                            done_kind_i == OP_WRLAST))
            pass_o <= !fail_i;
    end
endmodule

// File: rtl/pgstat_ctrl.sv
// Page address and status controller (top).
// Arbitrates decoded command strobes against busy, write lock and address
// validity; registers start/refuse/flag pulses and the effective address;
// drives the status byte and the ready/busy level on the serial output.
// Assumes at most one operation strobe per cycle.
module pgstat_ctrl
    import pgstat_pkg::*;
#(
    parameter bit          LARGE_DEV = 1'b0,
    parameter int unsigned BLK_W     = 8,
    parameter int unsigned PG_W      = 8,
    parameter int unsigned PAGES     = 128,
    parameter int unsigned T_READ    = 9,
    parameter int unsigned T_PROG    = 40,
    parameter int unsigned T_ERASE   = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             cmd_set_addr_i,
    input  logic [BLK_W-1:0] arg_blk_i,
    input  logic [PG_W-1:0]  arg_pg_i,
    input  logic             cmd_incr_i,
    input  logic             cmd_read_i,
    input  logic             cmd_write_i,
    input  logic             cmd_erase_i,
    input  logic             cmd_rd_last_i,
    input  logic             cmd_wr_last_i,
    input  logic             cmd_wen_i,
    input  logic             cmd_wdis_i,
    input  logic             arr_fail_i,
    input  logic             shift_out_i,
    input  logic             shift_bit_i,
    output logic             op_go_o,
    output logic [2:0]       op_kind_o,
    output logic [BLK_W-1:0] eff_blk_o,
    output logic [PG_W-1:0]  eff_pg_o,
    output logic             deny_o,
    output logic             addr_err_o,
    output logic             busy_o,
    output logic [7:0]       status_o,
    output logic             so_o,
    output logic             so_oe_o
);
    localparam int unsigned TOP_BLK    = LARGE_DEV ? 254 : 127;
    localparam int unsigned LAST_PAGES = LARGE_DEV ? 2 * PAGES : PAGES;

    logic             valid;
    logic [BLK_W-1:0] cur_blk;
    logic [PG_W-1:0]  cur_pg;
    logic             wel;
    logic             pass;
    logic             done;
    op_kind_t         done_kind;
    logic             erase_done;
    logic             ok_norm;
    logic             ok_last;
    logic             start;
    op_kind_t         st_kind;
    logic [BLK_W-1:0] st_blk;
    logic [PG_W-1:0]  st_pg;
    logic             den_d;
    logic             aerr_d;

    assign erase_done = done && (done_kind == OP_ERASE);

    pgstat_addr #(
        .BLK_W(BLK_W), .PG_W(PG_W), .PAGES(PAGES), .TOP_BLK(TOP_BLK)
    ) u_addr (
        .clk(clk), .rst_n(rst_n),
        .set_i(cmd_set_addr_i), .blk_i(arg_blk_i), .pg_i(arg_pg_i),
        .incr_i(cmd_incr_i), .inval_i(erase_done),
        .blk_o(cur_blk), .pg_o(cur_pg), .valid_o(valid)
    );

    pgstat_timer #(
        .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(st_kind),
        .busy_o(busy_o), .done_o(done), .done_kind_o(done_kind)
    );

    pgstat_status u_stat (
        .clk(clk), .rst_n(rst_n), .wen_i(cmd_wen_i), .wdis_i(cmd_wdis_i),
        .done_i(done), .done_kind_i(done_kind), .fail_i(arr_fail_i),
        .wel_o(wel), .pass_o(pass)
    );

    assign ok_norm = valid && (int'(cur_blk) < TOP_BLK) && (int'(cur_pg) < PAGES);
    assign ok_last = valid && (int'(cur_pg) < LAST_PAGES);

    // Decide start, refusal or address flag for an idle-time command.
    always_comb begin
        start   = 1'b0;
        st_kind = OP_NONE;
        st_blk  = cur_blk;
        st_pg   = cur_pg;
        den_d   = 1'b0;
        aerr_d  = 1'b0;
        if (!busy_o) begin
            if (cmd_read_i) begin
                if (ok_norm) begin start = 1'b1; st_kind = OP_READ; end
                else aerr_d = 1'b1;
            end else if (cmd_write_i) begin
                if (!ok_norm)  aerr_d = 1'b1;
                else if (!wel) den_d  = 1'b1;
                else begin start = 1'b1; st_kind = OP_WRITE; end
            end else if (cmd_erase_i) begin
                if (wel && (int'(arg_blk_i) < TOP_BLK)) begin
                    start   = 1'b1;
                    st_kind = OP_ERASE;
                    st_blk  = arg_blk_i;
                    st_pg   = '0;
                end else den_d = 1'b1;
            end else if (cmd_rd_last_i) begin
                if (ok_last) begin
                    start = 1'b1; st_kind = OP_RDLAST; st_blk = BLK_W'(TOP_BLK);
                end else aerr_d = 1'b1;
            end else if (cmd_wr_last_i) begin
                if (!ok_last)  aerr_d = 1'b1;
                else if (!wel) den_d  = 1'b1;
                else begin
                    start = 1'b1; st_kind = OP_WRLAST; st_blk = BLK_W'(TOP_BLK);
                end
            end
        end
    end

    // Register the outcome pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_go_o    <= 1'b0;
            deny_o     <= 1'b0;
            addr_err_o <= 1'b0;
        end else begin
            op_go_o    <= start;
            deny_o     <= den_d;
            addr_err_o <= aerr_d;
        end
    end

    // Hold the effective address and kind of the most recent start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind_o <= 3'(OP_NONE);
            eff_blk_o <= '0;
            eff_pg_o  <= '0;
        end else if (start) begin
            op_kind_o <= 3'(st_kind);
            eff_blk_o <= st_blk;
            eff_pg_o  <= st_pg;
        end
    end

    assign status_o = {!busy_o, pass, wel, 4'b0000, LARGE_DEV};
    assign so_oe_o  = !cs_n_i;
    assign so_o     = shift_out_i ? shift_bit_i : !busy_o;
endmodule

// File: rtl/pgstat_checker.sv
// Cycle-level property checker for pgstat_ctrl, attached by bind.
module pgstat_checker #(
    parameter bit          LARGE_DEV = 1'b0,
    parameter int unsigned BLK_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             shift_out_i,
    input logic             so_o,
    input logic             busy_o,
    input logic             op_go_o,
    input logic [2:0]       op_kind_o,
    input logic [BLK_W-1:0] eff_blk_o,
    input logic             deny_o,
    input logic             addr_err_o,
    input logic [7:0]       status_o
);
    localparam int unsigned TOP_BLK = LARGE_DEV ? 254 : 127;

    AST_GO_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_go_o |-> busy_o); // R5
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_go_o, deny_o, addr_err_o})); // R9
    AST_WRITE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go_o && (op_kind_o == 3'd2 || op_kind_o == 3'd3 || op_kind_o == 3'd5))
        |-> $past(status_o[5])); // R4
    AST_LAST_USES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go_o && (op_kind_o == 3'd4 || op_kind_o == 3'd5))
        |-> (int'(eff_blk_o) == TOP_BLK)); // R7
    AST_ERASE_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go_o && op_kind_o == 3'd3) |-> (int'(eff_blk_o) < TOP_BLK)); // R8
    AST_SO_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !shift_out_i && busy_o) |-> !so_o); // R10
    AST_ADDR_MOVES_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_blk_o != $past(eff_blk_o)) |-> op_go_o); // R2
endmodule

bind pgstat_ctrl pgstat_checker #(.LARGE_DEV(LARGE_DEV), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .shift_out_i(shift_out_i),
    .so_o(so_o), .busy_o(busy_o), .op_go_o(op_go_o), .op_kind_o(op_kind_o),
    .eff_blk_o(eff_blk_o), .deny_o(deny_o), .addr_err_o(addr_err_o),
    .status_o(status_o)
);

// File: tb/pgstat_ctrl_bench.sv
module pgstat_ctrl_bench;
    localparam int TR = 4, TP = 6, TE = 10;
    localparam int C_SET = 0, C_INC = 1, C_RD = 2, C_WR = 3, C_ER = 4,
                   C_RDL = 5, C_WRL = 6, C_WEN = 7, C_WDIS = 8;

    logic clk = 0, rst_n = 0, cs_n = 1;
    logic s_set = 0, s_inc = 0, s_rd = 0, s_wr = 0, s_er = 0, s_rdl = 0, s_wrl = 0;
    logic s_wen = 0, s_wdis = 0, fail = 0, shout = 0, shbit = 0;
    logic [7:0] a_blk = 0, a_pg = 0;
    logic go, den, aerr, busy, so, so_oe;
    logic [2:0] kind;
    logic [7:0] eblk, epg, st;

    int n_vec = 0, n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pgstat_ctrl #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) u_pgstat_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cmd_set_addr_i(s_set),
        .arg_blk_i(a_blk), .arg_pg_i(a_pg), .cmd_incr_i(s_inc), .cmd_read_i(s_rd),
        .cmd_write_i(s_wr), .cmd_erase_i(s_er), .cmd_rd_last_i(s_rdl),
        .cmd_wr_last_i(s_wrl), .cmd_wen_i(s_wen), .cmd_wdis_i(s_wdis),
        .arr_fail_i(fail), .shift_out_i(shout), .shift_bit_i(shbit),
        .op_go_o(go), .op_kind_o(kind), .eff_blk_o(eblk), .eff_pg_o(epg),
        .deny_o(den), .addr_err_o(aerr), .busy_o(busy), .status_o(st),
        .so_o(so), .so_oe_o(so_oe)
    );

    // Behavioural reference model
    int m_blk, m_pg, m_valid, m_wel, m_pass, m_cnt, m_kind;
    int m_go, m_den, m_aerr, m_eblk, m_epg;
    int okn, okl, was_busy;

    task automatic m_start(input int k, input int b, input int p, input int t);
        m_go = 1; m_kind = k; m_eblk = b; m_epg = p; m_cnt = t;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_blk = 0; m_pg = 0; m_valid = 0; m_wel = 0; m_pass = 1; m_cnt = 0;
            m_kind = 0; m_go = 0; m_den = 0; m_aerr = 0; m_eblk = 0; m_epg = 0;
        end else begin
            m_go = 0; m_den = 0; m_aerr = 0;
            okn = (m_valid != 0 && m_blk < 127 && m_pg < 128) ? 1 : 0;
            okl = (m_valid != 0 && m_pg < 128) ? 1 : 0;
            was_busy = (m_cnt != 0) ? 1 : 0;
            if (m_cnt == 1) begin
                if (m_kind == 2 || m_kind == 3 || m_kind == 5) m_pass = fail ? 0 : 1;
                if (m_kind == 3) m_valid = 0;
            end
            if (m_cnt != 0) m_cnt--;
            if (was_busy == 0) begin
                if (s_rd) begin
                    if (okn != 0) m_start(1, m_blk, m_pg, TR); else m_aerr = 1;
                end else if (s_wr) begin
                    if (okn == 0) m_aerr = 1;
                    else if (m_wel == 0) m_den = 1;
                    else m_start(2, m_blk, m_pg, TP);
                end else if (s_er) begin
                    if (m_wel != 0 && a_blk < 127) m_start(3, a_blk, 0, TE); else m_den = 1;
                end else if (s_rdl) begin
                    if (okl != 0) m_start(4, 127, m_pg, TR); else m_aerr = 1;
                end else if (s_wrl) begin
                    if (okl == 0) m_aerr = 1;
                    else if (m_wel == 0) m_den = 1;
                    else m_start(5, 127, m_pg, TP);
                end
            end
            if (s_inc) begin
                if (m_pg >= 127) begin
                    if (m_blk >= 126) m_valid = 0;
                    m_pg = 0; m_blk = (m_blk + 1) % 256;
                end else m_pg++;
            end
            if (s_set) begin m_blk = a_blk; m_pg = a_pg; m_valid = 1; end
            if (s_wen) m_wel = 1; else if (s_wdis) m_wel = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_st;
            exp_st = {m_cnt == 0, m_pass[0], m_wel[0], 5'b00000};
            chk(st == exp_st, "R6 status", st, exp_st);
            chk(busy == (m_cnt != 0), "R5 busy", busy, m_cnt != 0);
            chk(go == m_go[0], "R2 go", go, m_go);
            chk(den == m_den[0], "R4 deny", den, m_den);
            chk(aerr == m_aerr[0], "R9 addr_err", aerr, m_aerr);
            chk(int'(kind) == m_kind || m_go == 0, "R2 kind", kind, m_kind);
            chk(int'(eblk) == m_eblk, "R2 eff_blk", eblk, m_eblk);
            chk(int'(epg) == m_epg, "R2 eff_pg", epg, m_epg);
            chk(so_oe == !cs_n, "R10 so_oe", so_oe, !cs_n);
            if (!cs_n) begin
                if (shout) chk(so == shbit, "R10 so shift", so, shbit);
                else chk(so == (m_cnt == 0), "R10 so ready", so, m_cnt == 0);
            end
        end
    end

    task automatic cmd(input int c, input int b = 0, input int p = 0);
        @(posedge clk); #2;
        a_blk = 8'(b); a_pg = 8'(p);
        case (c)
            C_SET: s_set = 1; C_INC: s_inc = 1; C_RD: s_rd = 1; C_WR: s_wr = 1;
            C_ER: s_er = 1; C_RDL: s_rdl = 1; C_WRL: s_wrl = 1;
            C_WEN: s_wen = 1; default: s_wdis = 1;
        endcase
        @(posedge clk); #2;
        {s_set, s_inc, s_rd, s_wr, s_er, s_rdl, s_wrl, s_wen, s_wdis} = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        int bc;
        repeat (3) @(posedge clk);
        #2 rst_n = 1; cs_n = 0;
        @(negedge clk);
        chk(st == 8'hC0, "R1 reset status", st, 8'hC0);
        chk(st[0] == 1'b0, "R6 size bit", st[0], 0);
        cmd(C_RD); @(negedge clk);
        chk(aerr == 1, "R1 read before address flagged", aerr, 1);
        chk(go == 0, "R9 nothing started", go, 0);
        // R2 and R5: read at 3/5, busy length
        cmd(C_SET, 3, 5); cmd(C_RD); @(negedge clk);
        chk(go && kind == 3'd1 && eblk == 3 && epg == 5, "R2 read address", {eblk, epg}, 16'h0305);
        bc = 0; while (busy) begin bc++; @(negedge clk); end
        chk(bc == TR, "R5 read busy cycles", bc, TR);
        cmd(C_WR); @(negedge clk);
        chk(den == 1, "R4 write while locked refused", den, 1);
        // R4: unlock, write, lock while busy
        cmd(C_WEN); cmd(C_WR); @(negedge clk);
        chk(go && kind == 3'd2, "R4 write started", kind, 2);
        cmd(C_WDIS); @(negedge clk);
        chk(st[5] == 0 && busy, "R4 lock accepted while busy", st, 8'h40);
        cmd(C_RD); @(negedge clk);
        chk(go == 0 && aerr == 0 && den == 0, "R5 read while busy ignored", go, 0);
        wait_idle();
        chk(st[6] == 1, "R11 pass after write", st[6], 1);
        cmd(C_WR); @(negedge clk);
        chk(den == 1, "R4 write after lock refused", den, 1);
        // R11 failing write
        cmd(C_WEN); fail = 1; cmd(C_WR); wait_idle();
        chk(st[6] == 0, "R11 fail captured", st[6], 0);
        fail = 0; cmd(C_WR); wait_idle();
        chk(st[6] == 1, "R11 pass restored", st[6], 1);
        // R3 increment carry and overflow
        cmd(C_SET, 3, 127); cmd(C_INC); cmd(C_RD); @(negedge clk);
        chk(eblk == 4 && epg == 0, "R3 carry into next block", {eblk, epg}, 16'h0400);
        wait_idle();
        cmd(C_SET, 5, 20); cmd(C_INC); cmd(C_INC); cmd(C_RD); @(negedge clk);
        chk(eblk == 5 && epg == 22, "R3 plain increment", {eblk, epg}, 16'h0516);
        wait_idle();
        cmd(C_SET, 126, 127); cmd(C_INC); cmd(C_RD); @(negedge clk);
        chk(aerr == 1, "R3 overflow invalidates", aerr, 1);
        // R8 erase
        cmd(C_ER, 127); @(negedge clk);
        chk(den == 1, "R8 top block erase refused", den, 1);
        cmd(C_SET, 2, 9); cmd(C_ER, 2); @(negedge clk);
        chk(go && kind == 3'd3 && eblk == 2 && epg == 0, "R8 erase started", {eblk, epg}, 16'h0200);
        bc = 0; while (busy) begin bc++; @(negedge clk); end
        chk(bc == TE, "R5 erase busy cycles", bc, TE);
        cmd(C_RD); @(negedge clk);
        chk(aerr == 1, "R8 address invalid after erase", aerr, 1);
        // R7 top block
        cmd(C_SET, 9, 100); cmd(C_RDL); @(negedge clk);
        chk(go && kind == 3'd4 && eblk == 127 && epg == 100, "R7 top read", {eblk, epg}, 16'h7F64);
        wait_idle();
        cmd(C_SET, 9, 200); cmd(C_RDL); @(negedge clk);
        chk(aerr == 1, "R7 page beyond range on small variant", aerr, 1);
        cmd(C_SET, 9, 10); cmd(C_WRL); @(negedge clk);
        chk(go && kind == 3'd5 && eblk == 127, "R7 top write", eblk, 127);
        // R10 serial output
        chk(so == 0 && so_oe == 1, "R10 busy level", so, 0);
        cs_n = 1; @(negedge clk);
        chk(so_oe == 0 && busy == 1, "R10 deselect keeps op running", so_oe, 0);
        cs_n = 0; wait_idle();
        chk(so == 1, "R10 ready level", so, 1);
        shout = 1; shbit = 0; @(negedge clk);
        chk(so == 0, "R10 shift bit passes", so, 0);
        shout = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule